// File: doc/BRIEF.md
# Repeater Link Power-State Controller

This block runs the power management of one port of a signal-conditioning repeater. It does not decode any link protocol traffic. It infers the port's state from electrical conditions alone: a chip-enable pin, per-channel electrical-idle and low-frequency-periodic-signalling (LFPS) flags, and the result of a receiver-termination probe.

From that state it drives a set of enables for the analog slice:
- the datapath,
- the squelch detector,
- the LFPS detector,
- the termination poller,
- common-mode bias hold,
- high-impedance terminations.

It also reports the current state as a 3-bit code.

All timers count a free-running `tick` strobe, so every wait is set by a parameter in ticks. With a 1 µs tick the defaults give:
- a 300 ms idle wait,
- a 20 ms wake settle,
- a 1 ms poll period.

The chip-enable, idle, LFPS and termination inputs pass through two flip-flop stages before they are used.

Top module: `redrv_pm_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with `chip_en` low, `pstate` is 0 (shutdown), `term_hiz` is 1, and `path_en`, `squelch_en`, `lfps_en`, `poll_en` and `cm_hold` are 0.
- R2: When `chip_en` is low at a rising clock edge, `pstate` reads 0 no later than the third rising edge after it, whatever state the port was in.
- R3: In shutdown (code 0), `term_hiz`=1, `cm_hold`=0, and `path_en`, `squelch_en`, `lfps_en` and `poll_en` are all 0.
- R4: With `chip_en` high in shutdown, the port enters wake-settle (code 1). It stays there for `SETTLE_TICKS` tick strobes and then becomes active (code 2). In wake-settle, `cm_hold`=1 and every other control output is 0.
- R5: In active (code 2), `path_en`, `squelch_en`, `lfps_en` and `cm_hold` are 1, and `poll_en` and `term_hiz` are 0.
- R6: In active, after `IDLE_TICKS` consecutive tick strobes with every bit of `elec_idle` high, the port enters connected power-saving (code 4).
- R7: Any channel leaving electrical idle restarts the idle count. Non-idle gaps shorter than `IDLE_TICKS` ticks therefore keep the port active.
- R8: In both power-saving states, `path_en` and `term_hiz` are 0 and `squelch_en`, `lfps_en` and `poll_en` are 1. `cm_hold` is 1 in connected power-saving (code 4) and 0 in no-connection power-saving (code 3).
- R9: In power-saving, `term_det` is sampled once every `POLL_TICKS` ticks. A low sample moves code 4 to code 3, and a high sample moves code 3 to code 4.
- R10: LFPS on any channel in code 4 returns the port to active by the third rising edge after the flag is seen. LFPS in code 3 has no effect on the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Free-running one-cycle timebase strobe |
| chip_en | input | 1 | Chip enable; low forces shutdown |
| elec_idle | input | NCH | Per-channel electrical-idle indication |
| lfps_det | input | NCH | Per-channel LFPS-detected flag |
| term_det | input | 1 | Receiver termination probe result |
| path_en | output | 1 | Channel datapath enable |
| squelch_en | output | 1 | Squelch detector enable |
| lfps_en | output | 1 | LFPS detector enable |
| poll_en | output | 1 | Termination poller enable |
| cm_hold | output | 1 | Hold DC common-mode bias |
| term_hiz | output | 1 | Put Tx/Rx terminations in high impedance |
| pstate | output | 3 | State code: 0 shutdown, 1 wake-settle, 2 active, 3 no-connection power-saving, 4 connected power-saving |

## Verification
The bench drops chip enable in wake-settle, active and both power-saving states. A design that let any state ignore the override would stay powered with terminations attached.

It toggles one channel out of idle at intervals shorter than the idle wait. A design that counted total idle ticks instead of consecutive ones would then sleep while traffic is still present.

It raises LFPS in the no-connection state, where a design missing the connection qualifier would wake into active with no partner. It also drives both termination outcomes across poll boundaries to catch a missing or inverted poll decision.

Each state's six-bit enable pattern is compared in full, so a swapped bias-hold or high-impedance level shows up at once.

// File: rtl/redrv_pm_pkg.sv
package redrv_pm_pkg;

    typedef enum logic [2:0] {
        ST_SHUT      = 3'd0,
        ST_WAKE      = 3'd1,
        ST_ACTIVE    = 3'd2,
        ST_PS_NOCONN = 3'd3,
        ST_PS_CONN   = 3'd4
    } pm_state_e;

    typedef struct packed {
        logic path_en;
        logic squelch_en;
        logic lfps_en;
        logic poll_en;
        logic cm_hold;
        logic term_hiz;
    } pm_ctl_t;

    function automatic pm_ctl_t ctl_for(pm_state_e s);
        pm_ctl_t c;
        c = '{path_en: 1'b0, squelch_en: 1'b0, lfps_en: 1'b0,
              poll_en: 1'b0, cm_hold: 1'b0, term_hiz: 1'b1};
        unique case (s)
            ST_WAKE: begin
                c.term_hiz = 1'b0;
                c.cm_hold  = 1'b1;
            end
            ST_ACTIVE: begin
                c.term_hiz   = 1'b0;
                c.cm_hold    = 1'b1;
                c.path_en    = 1'b1;
                c.squelch_en = 1'b1;
                c.lfps_en    = 1'b1;
            end
            ST_PS_NOCONN, ST_PS_CONN: begin
                c.term_hiz   = 1'b0;
                c.cm_hold    = (s == ST_PS_CONN);
                c.squelch_en = 1'b1;
                c.lfps_en    = 1'b1;
                c.poll_en    = 1'b1;
            end
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/redrv_pm_sync.sv
module redrv_pm_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] s1_q, s2_q;
    logic [W-1:0] s1_d, s2_d;

    always_comb begin
        s1_d = din;
        s2_d = s1_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign dout = s2_q;
endmodule

// File: rtl/redrv_pm_timer.sv
module redrv_pm_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] cnt_q, cnt_d;

    always_comb begin
        hit   = run && tick && (cnt_q == limit - W'(1));
        cnt_d = cnt_q;
        if (!run)
            cnt_d = '0;
        else if (tick)
            cnt_d = hit ? '0 : cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // The count never runs past its limit while the timer is armed (R4, R6, R9)
    p_cnt_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < limit));
endmodule

// File: rtl/redrv_pm_ctrl.sv
module redrv_pm_ctrl
    import redrv_pm_pkg::*;
#(
    parameter int NCH          = 2,
    parameter int IDLE_TICKS   = 300000,
    parameter int SETTLE_TICKS = 20000,
    parameter int POLL_TICKS   = 1000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           chip_en,
    input  logic [NCH-1:0] elec_idle,
    input  logic [NCH-1:0] lfps_det,
    input  logic           term_det,
    output logic           path_en,
    output logic           squelch_en,
    output logic           lfps_en,
    output logic           poll_en,
    output logic           cm_hold,
    output logic           term_hiz,
    output logic [2:0]     pstate
);
    localparam int DWELL_MAX = (IDLE_TICKS > SETTLE_TICKS) ? IDLE_TICKS : SETTLE_TICKS;
    localparam int DWELL_W   = $clog2(DWELL_MAX + 1);
    localparam int POLL_W    = $clog2(POLL_TICKS + 1);
    localparam int SYNC_W    = 2 * NCH + 2;

    logic [SYNC_W-1:0] sync_in, sync_out;
    logic              ce_s, term_s;
    logic [NCH-1:0]    idle_s, lfps_s;

    assign sync_in = {chip_en, term_det, elec_idle, lfps_det};

    redrv_pm_sync #(.W(SYNC_W)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (sync_in),
        .dout (sync_out)
    );

    assign ce_s   = sync_out[SYNC_W-1];
    assign term_s = sync_out[SYNC_W-2];
    assign idle_s = sync_out[2*NCH-1:NCH];
    assign lfps_s = sync_out[NCH-1:0];

    pm_state_e    state_q, state_d;
    logic         all_idle;
    logic         dwell_run, dwell_hit, poll_run, poll_hit;
    logic [DWELL_W-1:0] dwell_lim;

    assign all_idle  = &idle_s;
    assign dwell_run = (state_q == ST_WAKE) || ((state_q == ST_ACTIVE) && all_idle);
    assign dwell_lim = (state_q == ST_WAKE) ? DWELL_W'(SETTLE_TICKS) : DWELL_W'(IDLE_TICKS);
    assign poll_run  = (state_q == ST_PS_CONN) || (state_q == ST_PS_NOCONN);

    redrv_pm_timer #(.W(DWELL_W)) u_dwell (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (dwell_run),
        .tick (tick),
        .limit(dwell_lim),
        .hit  (dwell_hit)
    );

    redrv_pm_timer #(.W(POLL_W)) u_poll (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (poll_run),
        .tick (tick),
        .limit(POLL_W'(POLL_TICKS)),
        .hit  (poll_hit)
    );

    always_comb begin
        state_d = state_q;
        if (!ce_s) begin
            state_d = ST_SHUT;
        end else begin
            unique case (state_q)
                ST_SHUT:      state_d = ST_WAKE;
                ST_WAKE:      if (dwell_hit) state_d = ST_ACTIVE;
                ST_ACTIVE:    if (dwell_hit) state_d = ST_PS_CONN;
                ST_PS_CONN: begin
                    if (|lfps_s)                  state_d = ST_ACTIVE;
                    else if (poll_hit && !term_s) state_d = ST_PS_NOCONN;
                end
                ST_PS_NOCONN: if (poll_hit && term_s) state_d = ST_PS_CONN;
                default:      state_d = ST_SHUT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SHUT;
        else        state_q <= state_d;
    end

    pm_ctl_t ctl;
    assign ctl        = ctl_for(state_q);
    assign path_en    = ctl.path_en;
    assign squelch_en = ctl.squelch_en;
    assign lfps_en    = ctl.lfps_en;
    assign poll_en    = ctl.poll_en;
    assign cm_hold    = ctl.cm_hold;
    assign term_hiz   = ctl.term_hiz;
    assign pstate     = state_q;

    // A low synchronised enable always lands in shutdown on the next edge (R2)
    p_ce_forces_shut_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_s |=> (state_q == ST_SHUT));

    // Shutdown only leaves through wake-settle (R4)
    p_shut_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHUT) |=> (state_q == ST_SHUT || state_q == ST_WAKE));

    // LFPS with a connection wakes the port in one state step (R10)
    p_lfps_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PS_CONN && ce_s && |lfps_s) |=> (state_q == ST_ACTIVE));

    // No-connection power-saving never jumps straight to active (R10)
    p_noconn_no_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PS_NOCONN) |=> (state_q != ST_ACTIVE));

    // Active is left for power-saving only after the idle timer expires (R6)
    p_idle_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && ce_s && !dwell_hit) |=> (state_q == ST_ACTIVE));

    // Terminations are high impedance exactly when datapath bias is dropped in shutdown (R3)
    p_hiz_no_bias_r3: assert property (@(posedge clk) disable iff (!rst_n)
        term_hiz |-> (!cm_hold && !path_en && !poll_en));
endmodule

// File: tb/redrv_pm_ctrl_test.sv
module redrv_pm_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 2;
    localparam int IDLE_T     = 8;
    localparam int SETTLE_T   = 5;
    localparam int POLL_T     = 4;
    localparam int TICK_DIV   = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           tick = 1'b0;
    logic           chip_en = 1'b0;
    logic [NCH-1:0] elec_idle = '1;
    logic [NCH-1:0] lfps_det = '0;
    logic           term_det = 1'b1;
    logic path_en, squelch_en, lfps_en, poll_en, cm_hold, term_hiz;
    logic [2:0] pstate;

    int n_run = 0;
    int n_fail = 0;

    redrv_pm_ctrl #(.NCH(NCH), .IDLE_TICKS(IDLE_T), .SETTLE_TICKS(SETTLE_T),
                    .POLL_TICKS(POLL_T)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .chip_en(chip_en),
        .elec_idle(elec_idle), .lfps_det(lfps_det), .term_det(term_det),
        .path_en(path_en), .squelch_en(squelch_en), .lfps_en(lfps_en),
        .poll_en(poll_en), .cm_hold(cm_hold), .term_hiz(term_hiz), .pstate(pstate));

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        int k;
        k = 0;
        forever begin
            @(negedge clk);
            k = k + 1;
            tick = (k % TICK_DIV) == 0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        n_run++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
        end
    endtask

    // expected {path,squelch,lfps,poll,cm_hold,hiz} per state, from R3, R4, R5, R8
    function automatic logic [5:0] exp_ctl(input logic [2:0] s);
        case (s)
            3'd1:    return 6'b000010;
            3'd2:    return 6'b111010;
            3'd3:    return 6'b011100;
            3'd4:    return 6'b011110;
            default: return 6'b000001;
        endcase
    endfunction

    task automatic check_pat(input string req, input logic [2:0] s);
        check(req, {26'd0, path_en, squelch_en, lfps_en, poll_en, cm_hold, term_hiz},
              {26'd0, exp_ctl(s)});
    endtask

    task automatic wait_state(input string req, input logic [2:0] s, input int max_cyc);
        int n;
        n = 0;
        while (pstate !== s && n < max_cyc) begin
            @(negedge clk);
            n++;
        end
        check(req, {29'd0, pstate}, {29'd0, s});
    endtask

    task automatic go_active();
        chip_en = 1'b1;
        wait_state("R4", 3'd2, 40);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1", {29'd0, pstate}, 32'd0);
        check_pat("R1", 3'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1", {29'd0, pstate}, 32'd0);
        check_pat("R3", 3'd0);
    endtask

    task automatic t_wake();
        chip_en = 1'b1;
        repeat (3) @(negedge clk);
        check("R4", {29'd0, pstate}, 32'd1);
        check_pat("R4", 3'd1);
        repeat (SETTLE_T * TICK_DIV - 4) @(negedge clk);
        check("R4 settle not early", {29'd0, pstate}, 32'd1);
        wait_state("R4", 3'd2, 12);
        check_pat("R5", 3'd2);
    endtask

    task automatic t_idle_restart();
        elec_idle = '1;
        for (int i = 0; i < 10; i++) begin
            repeat (3 * TICK_DIV) @(negedge clk);
            elec_idle[i % NCH] = 1'b0;
            @(negedge clk);
            elec_idle = '1;
        end
        check("R7", {29'd0, pstate}, 32'd2);
    endtask

    task automatic t_idle();
        elec_idle = '1;
        repeat (IDLE_T * TICK_DIV / 2) @(negedge clk);
        check("R6 not early", {29'd0, pstate}, 32'd2);
        wait_state("R6", 3'd4, IDLE_T * TICK_DIV + 8);
        check_pat("R8", 3'd4);
    endtask

    task automatic t_poll();
        term_det = 1'b0;
        wait_state("R9", 3'd3, POLL_T * TICK_DIV + 8);
        check_pat("R8", 3'd3);
        term_det = 1'b1;
        wait_state("R9", 3'd4, POLL_T * TICK_DIV + 8);
    endtask

    task automatic t_lfps();
        term_det = 1'b0;
        wait_state("R9", 3'd3, POLL_T * TICK_DIV + 8);
        lfps_det = 2'b10;
        repeat (12) @(negedge clk);
        lfps_det = '0;
        check("R10 ignored without connection", {29'd0, pstate}, 32'd3);
        term_det = 1'b1;
        wait_state("R9", 3'd4, POLL_T * TICK_DIV + 8);
        lfps_det = 2'b10;
        repeat (3) @(negedge clk);
        lfps_det = '0;
        check("R10", {29'd0, pstate}, 32'd2);
        check_pat("R5", 3'd2);
    endtask

    task automatic ce_drop(input string where);
        chip_en = 1'b0;
        repeat (3) @(negedge clk);
        check({"R2 from ", where}, {29'd0, pstate}, 32'd0);
        check_pat("R3", 3'd0);
    endtask

    task automatic t_ce_drops();
        ce_drop("active");
        chip_en = 1'b1;
        repeat (5) @(negedge clk);
        ce_drop("wake");
        go_active();
        elec_idle = '1;
        wait_state("R6", 3'd4, IDLE_T * TICK_DIV + 8);
        ce_drop("ps_conn");
        go_active();
        wait_state("R6", 3'd4, IDLE_T * TICK_DIV + 8);
        term_det = 1'b0;
        wait_state("R9", 3'd3, POLL_T * TICK_DIV + 8);
        ce_drop("ps_noconn");
        term_det = 1'b1;
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_wake();
        t_idle_restart();
        t_idle();
        t_poll();
        t_lfps();
        t_ce_drops();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule